// File: doc/BRIEF.md
# Clock Stop and Power-Down Sequencer

This block sits between a set of clock sources and the clock outputs of a timing generator. It gates each output group cleanly. One active-low request parks the processor clocks and the 66 MHz bus clocks. A second parks the PCI clocks, but leaves the free-running PCI output alone. A third powers the block down. Every request may arrive at any time. Each one is passed through a two-flop synchronizer in the domain of the clock it gates. A gate enable changes only on a falling edge of its own source. As a result, a gated output parks low and restarts with a full-width first high phase.

Power-down is run by a sequencer in the master-clock domain. First it withdraws the run permission from every group, including the reference, USB and free-running PCI outputs. It then waits a parking interval of `PARK_CYC` master cycles, so that the slowest group has parked. Only then does it drop the oscillator and VCO enables. On release, the oscillator enable rises first and the VCO enable follows one cycle later. A settle counter of `SETTLE_CYC` master cycles must then expire before the groups may run again. The integrator sizes `SETTLE_CYC` so that the full power-up stays below 3 ms.

Top module: `clk_stop_seq`

## Requirements
- R1: While `cpu_stop_n` is low (and power-down is not active), all `cpu_clk` and `bus_clk` outputs are held low. `io_clk`, `pci_clk`, `pci_free_clk`, `ref_clk` and `usb_clk` keep toggling.
- R2: While `pci_stop_n` is low, all `pci_clk` outputs are held low. `pci_free_clk`, `cpu_clk` and the other groups keep toggling.
- R3: Consider a stop request that changes between source edges. A stopping output still passes exactly two further rising edges of its source, and is low from the third. A restarting output has its first rising edge on the third rising edge of its source after the change.
- R4: A stopped output rests at logic 0. The first high phase after a restart equals the source high phase: 5 ns for `cpu_src`, 15 ns for `pci_src` in the bench set-up.
- R5: After `pwr_dn_n` falls between master edges, `osc_en` and `vco_en` go low after master rising edge number PARK_CYC+3, counted from the change. At that moment every clock output is already low.
- R6: While powered down, toggling `cpu_stop_n` and `pci_stop_n` has no effect: no clock output shows a rising edge.
- R7: After `pwr_dn_n` rises between master edges, `osc_en` goes high after the third master rising edge and `vco_en` after the fourth. The VCO enable never rises before the oscillator enable.
- R8: No clock output rises during the SETTLE_CYC master cycles that follow the `osc_en` rise. After that, all groups resume toggling.
- R9: While `rst_n` is low, all clock outputs, `osc_en` and `vco_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mst_clk | input | 1 | Master clock for the power-down sequencer |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_src | input | 1 | Processor clock source |
| bus_src | input | 1 | 66 MHz bus clock source |
| io_src | input | 1 | Interrupt-controller clock source |
| pci_src | input | 1 | PCI clock source (also feeds the free-running output) |
| ref_src | input | 1 | Reference clock source |
| usb_src | input | 1 | 48 MHz clock source |
| cpu_stop_n | input | 1 | Asynchronous stop request for processor and bus clocks, active low |
| pci_stop_n | input | 1 | Asynchronous stop request for PCI clocks, active low |
| pwr_dn_n | input | 1 | Asynchronous power-down request, active low |
| cpu_clk | output | N_CPU | Gated processor clocks |
| bus_clk | output | N_BUS | Gated 66 MHz bus clocks |
| io_clk | output | N_IO | Gated interrupt-controller clocks |
| pci_clk | output | N_PCI | Stoppable PCI clocks |
| pci_free_clk | output | 1 | Free-running PCI clock, gated only by power-down |
| ref_clk | output | N_REF | Reference clocks, gated only by power-down |
| usb_clk | output | 1 | 48 MHz clock, gated only by power-down |
| osc_en | output | 1 | Oscillator enable |
| vco_en | output | 1 | VCO enable |

## Verification
The hardest state to reach is power-down with stop requests changing underneath it. The bench reaches that state only after counting the exact master edge on which the oscillator enable drops. Once there, it toggles both stop inputs and counts output edges to show that nothing escapes. The restart corner is hard to see without internal probes. The bench handles it by counting source rising edges up to the first gated rising edge, and by timing that first high phase against the source half period.

// File: rtl/clk_seq_pkg.sv
// Shared types for the clock stop and power-down sequencer.
package clk_seq_pkg;
    // Power sequencer states: clocks only run in PS_RUN.
    typedef enum logic [1:0] {
        PS_OFF    = 2'd0,
        PS_SETTLE = 2'd1,
        PS_RUN    = 2'd2,
        PS_PARK   = 2'd3
    } pwr_state_t;
endpackage

// File: rtl/clk_gate_grp.sv
// Glitch-free gate for one group of clocks driven by one source.
// Synchronizes two asynchronous permissions (stop request, run grant)
// with two flops each on the source's rising edge. The combined enable is
// captured on the falling edge, so the enable only changes while the
// source is low. Assumes rst_n is held for several source periods.
module clk_gate_grp #(
    parameter int WIDTH = 1
) (
    input  logic             src_clk,
    input  logic             rst_n,
    input  logic             req_n,
    input  logic             allow,
    output logic [WIDTH-1:0] gclk
);
    logic [1:0] req_sync;
    logic [1:0] allow_sync;
    logic       en_q;

    // Two-flop synchronizers for both permissions.
    always_ff @(posedge src_clk) begin
        if (!rst_n) begin
            req_sync   <= 2'b00;
            allow_sync <= 2'b00;
        end else begin
            req_sync   <= {req_sync[0], req_n};
            allow_sync <= {allow_sync[0], allow};
        end
    end

    // Enable updates on the falling edge, i.e. while the source is low.
    always_ff @(negedge src_clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= req_sync[1] & allow_sync[1];
    end

    // Fan the gated source out to every output of the group.
    for (genvar i = 0; i < WIDTH; i++) begin : g_fan
        assign gclk[i] = src_clk & en_q;
    end

    // A stop seen by the synchronizer has closed the gate by the next rise.
    assert_stop_low_R3: assert property (@(posedge src_clk) disable iff (!rst_n)
        $fell(req_sync[1]) |-> !en_q);
    // A revoked run grant likewise closes the gate by the next rise.
    assert_grant_low_R5: assert property (@(posedge src_clk) disable iff (!rst_n)
        $fell(allow_sync[1]) |-> !en_q);
endmodule

// File: rtl/pwr_seq_fsm.sv
// Power-down sequencer in the master clock domain.
// Synchronizes the power-down request, withdraws the run grant, waits
// PARK_CYC cycles for all groups to park, then drops oscillator and VCO
// enables. On release: oscillator first, VCO one cycle later, then a
// SETTLE_CYC cycle wait before granting run again.
module pwr_seq_fsm
    import clk_seq_pkg::*;
#(
    parameter int PARK_CYC   = 64,
    parameter int SETTLE_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_n,
    output logic run_ok,
    output logic osc_en,
    output logic vco_en
);
    localparam int MAX_CYC = (PARK_CYC > SETTLE_CYC) ? PARK_CYC : SETTLE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PARK_LAST   = CNT_W'(PARK_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_MIN  = CNT_W'(SETTLE_CYC);

    logic [1:0]       pd_sync;
    pwr_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             osc_d1;
    logic [CNT_W-1:0] on_cnt;

    // Two-flop synchronizer of the power-down request (1 = stay up).
    always_ff @(posedge clk) begin
        if (!rst_n) pd_sync <= 2'b00;
        else        pd_sync <= {pd_sync[0], pd_n};
    end

    // Next-state and interval counter logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        case (state_q)
            PS_OFF: if (pd_sync[1]) begin
                state_d = PS_SETTLE;
                cnt_d   = '0;
            end
            PS_SETTLE: begin
                if (!pd_sync[1]) begin
                    state_d = PS_OFF;
                    cnt_d   = '0;
                end else if (cnt_q == SETTLE_LAST) begin
                    state_d = PS_RUN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            PS_RUN: if (!pd_sync[1]) begin
                state_d = PS_PARK;
                cnt_d   = '0;
            end
            PS_PARK: begin
                if (cnt_q == PARK_LAST) begin
                    state_d = PS_OFF;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: state_d = PS_OFF;
        endcase
    end

    // State and counter registers; reset starts powered down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Delayed oscillator enable to stagger the VCO enable by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) osc_d1 <= 1'b0;
        else        osc_d1 <= osc_en;
    end

    assign osc_en = (state_q != PS_OFF);
    assign vco_en = osc_en & osc_d1;
    assign run_ok = (state_q == PS_RUN);

    // Checker counter: cycles since the oscillator enable rose, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !osc_en)  on_cnt <= '0;
        else if (on_cnt != '1)  on_cnt <= on_cnt + CNT_W'(1);
    end

    assert_settle_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_ok) |-> (on_cnt >= SETTLE_MIN));
    assert_run_needs_pll_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run_ok |-> (osc_en && vco_en));
    assert_vco_after_osc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vco_en) |-> $past(osc_en));
    assert_park_before_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> !$past(run_ok));
endmodule

// File: rtl/clk_stop_seq.sv
// Top of the clock stop and power-down sequencer.
// Gates each output group from its own source. Processor and bus groups
// obey cpu_stop_n, the PCI group obeys pci_stop_n, and every group,
// including free-running PCI, reference and USB, obeys the power-down
// sequencer's run grant. Assumes PARK_CYC covers about three periods of
// the slowest source plus synchronizer delay.
module clk_stop_seq #(
    parameter int N_CPU      = 6,
    parameter int N_BUS      = 2,
    parameter int N_IO       = 3,
    parameter int N_PCI      = 5,
    parameter int N_REF      = 2,
    parameter int PARK_CYC   = 64,
    parameter int SETTLE_CYC = 100
) (
    input  logic             mst_clk,
    input  logic             rst_n,
    input  logic             cpu_src,
    input  logic             bus_src,
    input  logic             io_src,
    input  logic             pci_src,
    input  logic             ref_src,
    input  logic             usb_src,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             pwr_dn_n,
    output logic [N_CPU-1:0] cpu_clk,
    output logic [N_BUS-1:0] bus_clk,
    output logic [N_IO-1:0]  io_clk,
    output logic [N_PCI-1:0] pci_clk,
    output logic             pci_free_clk,
    output logic [N_REF-1:0] ref_clk,
    output logic             usb_clk,
    output logic             osc_en,
    output logic             vco_en
);
    logic run_ok;

    pwr_seq_fsm #(.PARK_CYC(PARK_CYC), .SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk(mst_clk), .rst_n(rst_n), .pd_n(pwr_dn_n),
        .run_ok(run_ok), .osc_en(osc_en), .vco_en(vco_en));

    clk_gate_grp #(.WIDTH(N_CPU)) u_cpu (
        .src_clk(cpu_src), .rst_n(rst_n), .req_n(cpu_stop_n),
        .allow(run_ok), .gclk(cpu_clk));
    clk_gate_grp #(.WIDTH(N_BUS)) u_bus (
        .src_clk(bus_src), .rst_n(rst_n), .req_n(cpu_stop_n),
        .allow(run_ok), .gclk(bus_clk));
    clk_gate_grp #(.WIDTH(N_IO)) u_io (
        .src_clk(io_src), .rst_n(rst_n), .req_n(1'b1),
        .allow(run_ok), .gclk(io_clk));
    clk_gate_grp #(.WIDTH(N_PCI)) u_pci (
        .src_clk(pci_src), .rst_n(rst_n), .req_n(pci_stop_n),
        .allow(run_ok), .gclk(pci_clk));
    clk_gate_grp #(.WIDTH(1)) u_pcif (
        .src_clk(pci_src), .rst_n(rst_n), .req_n(1'b1),
        .allow(run_ok), .gclk(pci_free_clk));
    clk_gate_grp #(.WIDTH(N_REF)) u_ref (
        .src_clk(ref_src), .rst_n(rst_n), .req_n(1'b1),
        .allow(run_ok), .gclk(ref_clk));
    clk_gate_grp #(.WIDTH(1)) u_usb (
        .src_clk(usb_src), .rst_n(rst_n), .req_n(1'b1),
        .allow(run_ok), .gclk(usb_clk));

    // Every output is parked low whenever the oscillator is off.
    assert_all_low_when_off_R5: assert property (@(posedge mst_clk) disable iff (!rst_n)
        !osc_en |-> (cpu_clk == '0 && bus_clk == '0 && io_clk == '0 && pci_clk == '0
                     && !pci_free_clk && ref_clk == '0 && !usb_clk));
endmodule

// File: tb/sim_clk_stop_seq.sv
`timescale 1ns/1ps
module sim_clk_stop_seq;
    localparam int PARK   = 64;
    localparam int SETTLE = 100;
    localparam int E_CPU = 0, E_BUS = 1, E_IO = 2, E_PCI = 3, E_PCIF = 4,
                   E_REF = 5, E_USB = 6, S_CPU = 7, S_PCI = 8;

    logic mst_clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_src = 1'b0, bus_src = 1'b0, io_src = 1'b0, pci_src = 1'b0,
          ref_src = 1'b0, usb_src = 1'b0;
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_dn_n = 1'b1;
    logic [5:0] cpu_clk;
    logic [1:0] bus_clk;
    logic [2:0] io_clk;
    logic [4:0] pci_clk;
    logic       pci_free_clk;
    logic [1:0] ref_clk;
    logic       usb_clk, osc_en, vco_en;

    always #2.5 mst_clk = ~mst_clk;   // 200 MHz

    int tick = 0;
    always @(posedge mst_clk) begin
        tick <= tick + 1;
        cpu_src <= ~cpu_src;
        if (tick % 2 == 1) bus_src <= ~bus_src;
        if (tick % 2 == 1) usb_src <= ~usb_src;
        if (tick % 3 == 2) pci_src <= ~pci_src;
        if (tick % 6 == 5) io_src  <= ~io_src;
        if (tick % 7 == 6) ref_src <= ~ref_src;
    end

    clk_stop_seq #(.PARK_CYC(PARK), .SETTLE_CYC(SETTLE)) u0 (
        .mst_clk(mst_clk), .rst_n(rst_n), .cpu_src(cpu_src), .bus_src(bus_src),
        .io_src(io_src), .pci_src(pci_src), .ref_src(ref_src), .usb_src(usb_src),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwr_dn_n(pwr_dn_n),
        .cpu_clk(cpu_clk), .bus_clk(bus_clk), .io_clk(io_clk), .pci_clk(pci_clk),
        .pci_free_clk(pci_free_clk), .ref_clk(ref_clk), .usb_clk(usb_clk),
        .osc_en(osc_en), .vco_en(vco_en));

    // Rising-edge counters on outputs and two sources.
    int cnt_e [9];
    int snap [9];
    initial foreach (cnt_e[i]) cnt_e[i] = 0;
    always @(posedge cpu_clk[0])   cnt_e[E_CPU]++;
    always @(posedge bus_clk[0])   cnt_e[E_BUS]++;
    always @(posedge io_clk[0])    cnt_e[E_IO]++;
    always @(posedge pci_clk[0])   cnt_e[E_PCI]++;
    always @(posedge pci_free_clk) cnt_e[E_PCIF]++;
    always @(posedge ref_clk[0])   cnt_e[E_REF]++;
    always @(posedge usb_clk)      cnt_e[E_USB]++;
    always @(posedge cpu_src)      cnt_e[S_CPU]++;
    always @(posedge pci_src)      cnt_e[S_PCI]++;

    // Scoreboard: driver pushes expected items, monitor pops and compares.
    typedef struct { string req; string what; int exp; } exp_t;
    exp_t exp_q[$];
    int   obs_q[$];
    event chk_ev;
    int n_chk = 0, n_err = 0;

    task automatic expect_eq(string req, string what, int exp, int act);
        exp_q.push_back('{req, what, exp});
        obs_q.push_back(act);
        -> chk_ev;
    endtask

    task automatic drain();
        exp_t e;
        int a;
        while (exp_q.size() > 0 && obs_q.size() > 0) begin
            e = exp_q.pop_front();
            a = obs_q.pop_front();
            n_chk++;
            if (a != e.exp) begin
                n_err++;
                $display("FAIL %s %s: actual %0d expected %0d", e.req, e.what, a, e.exp);
            end
        end
    endtask

    initial forever begin
        @(chk_ev);
        drain();
    end

    task automatic take_snap();
        foreach (snap[i]) snap[i] = cnt_e[i];
    endtask

    function automatic int dlt(int idx);
        return cnt_e[idx] - snap[idx];
    endfunction

    function automatic int all_low();
        return int'(cpu_clk == '0 && bus_clk == '0 && io_clk == '0 && pci_clk == '0
                    && !pci_free_clk && ref_clk == '0 && !usb_clk);
    endfunction

    task automatic cycles(int n);
        repeat (n) @(posedge mst_clk);
        @(negedge mst_clk);
    endtask

    task automatic finish_run();
        #1;
        drain();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        realtime t0;
        int s0;
        // R9: reset state.
        cycles(40);
        expect_eq("R9", "outputs low in reset", 1, all_low());
        expect_eq("R9", "osc_en in reset", 0, int'(osc_en));
        expect_eq("R9", "vco_en in reset", 0, int'(vco_en));
        rst_n = 1'b1;
        cycles(200);
        take_snap();
        cycles(100);
        foreach (snap[i]) if (i < 7)
            expect_eq("R8", $sformatf("group %0d runs after start-up", i), 1, int'(dlt(i) > 0));

        // R1/R3: processor stop.
        take_snap();
        cpu_stop_n = 1'b0;
        cycles(200);
        expect_eq("R3", "cpu edges after stop", 2, dlt(E_CPU));
        expect_eq("R3", "bus edges after stop", 2, dlt(E_BUS));
        expect_eq("R1", "cpu group low", 1, int'(cpu_clk == '0 && bus_clk == '0));
        expect_eq("R1", "io runs", 1, int'(dlt(E_IO) > 0));
        expect_eq("R1", "pci runs", 1, int'(dlt(E_PCI) > 0));
        expect_eq("R1", "pci free runs", 1, int'(dlt(E_PCIF) > 0));
        expect_eq("R1", "ref runs", 1, int'(dlt(E_REF) > 0));
        expect_eq("R1", "usb runs", 1, int'(dlt(E_USB) > 0));
        s0 = cnt_e[S_CPU];
        cpu_stop_n = 1'b1;
        @(posedge cpu_clk[0]);
        t0 = $realtime;
        #0.5;
        expect_eq("R3", "cpu source edges to restart", 3, cnt_e[S_CPU] - s0);
        @(negedge cpu_clk[0]);
        expect_eq("R4", "cpu first high ps", 5000, int'(($realtime - t0) * 1000.0));
        cycles(20);

        // R2/R3: PCI stop.
        take_snap();
        pci_stop_n = 1'b0;
        cycles(200);
        expect_eq("R3", "pci edges after stop", 2, dlt(E_PCI));
        expect_eq("R2", "pci low", 1, int'(pci_clk == '0));
        expect_eq("R2", "pci free runs", 1, int'(dlt(E_PCIF) > 0));
        expect_eq("R2", "cpu runs", 1, int'(dlt(E_CPU) > 0));
        s0 = cnt_e[S_PCI];
        pci_stop_n = 1'b1;
        @(posedge pci_clk[0]);
        t0 = $realtime;
        #0.5;
        expect_eq("R3", "pci source edges to restart", 3, cnt_e[S_PCI] - s0);
        @(negedge pci_clk[0]);
        expect_eq("R4", "pci first high ps", 15000, int'(($realtime - t0) * 1000.0));
        cycles(20);

        // R5: power-down sequence timing.
        pwr_dn_n = 1'b0;
        cycles(PARK + 2);
        expect_eq("R5", "osc_en before park ends", 1, int'(osc_en));
        cycles(1);
        expect_eq("R5", "osc_en after park", 0, int'(osc_en));
        expect_eq("R5", "vco_en after park", 0, int'(vco_en));
        expect_eq("R5", "all outputs low", 1, all_low());

        // R6: stop inputs ignored while powered down.
        take_snap();
        cpu_stop_n = 1'b0;
        pci_stop_n = 1'b0;
        cycles(30);
        cpu_stop_n = 1'b1;
        pci_stop_n = 1'b1;
        cycles(100);
        expect_eq("R6", "edges while down", 0,
                  dlt(E_CPU) + dlt(E_BUS) + dlt(E_IO) + dlt(E_PCI) + dlt(E_PCIF) + dlt(E_REF) + dlt(E_USB));
        expect_eq("R6", "osc stays off", 0, int'(osc_en));

        // R7/R8: power-up sequence.
        take_snap();
        pwr_dn_n = 1'b1;
        cycles(2);
        expect_eq("R7", "osc_en after 2 edges", 0, int'(osc_en));
        cycles(1);
        expect_eq("R7", "osc_en after 3 edges", 1, int'(osc_en));
        expect_eq("R7", "vco_en after 3 edges", 0, int'(vco_en));
        cycles(1);
        expect_eq("R7", "vco_en after 4 edges", 1, int'(vco_en));
        cycles(SETTLE - 1);
        expect_eq("R8", "no edges during settle", 0,
                  dlt(E_CPU) + dlt(E_BUS) + dlt(E_IO) + dlt(E_PCI) + dlt(E_PCIF) + dlt(E_REF) + dlt(E_USB));
        cycles(200);
        expect_eq("R8", "cpu resumes", 1, int'(dlt(E_CPU) > 0));
        expect_eq("R8", "ref resumes", 1, int'(dlt(E_REF) > 0));
        expect_eq("R8", "pci free resumes", 1, int'(dlt(E_PCIF) > 0));
        finish_run();
    end
endmodule